// File: doc/BRIEF.md
# Commit-Protected GPIO Pad Configuration Bank

This block holds the pad configuration of one eight-pin general-purpose I/O port. There are four per-pin settings: alternate-function select, weak pull-up, weak pull-down and digital enable. A simple register-bus slave gives access to them. It takes an address, write data, a write strobe and a read strobe, and it returns registered read data. The stored settings drive per-pin pad-control outputs.

Some pins carry critical functions such as debug access or a non-maskable interrupt. To guard them, every pad register write is masked by a commit register, and only set commit bits let a write through. The commit register can change only while a keyed lock is open. The lock opens when one fixed 32-bit key is written and closes on any other value.

Reset values are parameters. A pin whose commit bit resets to 0 therefore comes out of reset locked. The pull-up and pull-down settings of a pin can never both be set. Their path to the pad takes either one or two clocks, chosen by a parameter.

Top module: `gpio_padcfg_bank`

## Requirements
- R1: Byte offsets are decoded as follows: alternate-function select 0x420, pull-up 0x510, pull-down 0x514, digital enable 0x51C, lock 0x520, commit 0x524. Read data is registered: `rd_data_o` shows the addressed value from the clock edge that samples `rd_en_i`.
- R2: In every pad register and in the commit register, only bits 7:0 hold state. Bits 31:8 always read as zero, and writes to them are discarded.
- R3: Writing 1 to a pull-up bit clears the same pin's pull-down bit, and writing 1 to a pull-down bit clears the same pin's pull-up bit. Writing 0 to either register leaves the other register unchanged. The pull-up and pull-down bits of a pin are never both 1.
- R4: A write to the alternate-function, pull-up, pull-down or digital-enable register changes only the bits whose commit bit is 1. This includes the clearing of the opposite pull bit. All other bits keep their value.
- R5: The lock is closed after reset. Writing the key 0x5AFEC0DE to the lock offset opens it, and writing any other value closes it. Reading the lock offset returns 1 while the lock is closed and 0 while it is open.
- R6: Writes to the commit register are ignored while the lock is closed. While the lock is open, bits 7:0 of the write data replace the commit bits.
- R7: Reset loads the parameter defaults. These are all-zero pad registers and a commit value of 0xFE, which leaves pin 0 locked. All pad outputs therefore start at zero.
- R8: With the default slow pull path, `pad_pu_o` and `pad_pd_o` change on the second clock edge after the write is sampled. With the fast pull path they change on the first. `pad_afsel_o` and `pad_den_o` change on the edge that samples the write.
- R9: A read of an unmapped offset returns zero. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| addr_i | input | 12 | Byte offset within the port |
| wr_data_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| pad_afsel_o | output | 8 | Per-pin alternate-function select |
| pad_pu_o | output | 8 | Per-pin weak pull-up enable |
| pad_pd_o | output | 8 | Per-pin weak pull-down enable |
| pad_den_o | output | 8 | Per-pin digital enable |

## Verification
The bench writes all-ones patterns while pin 0 is locked. The read-back then shows whether the commit mask is applied per bit or ignored. Overlapping pull-up and pull-down patterns (0x0F then 0x3C) separate "a 1 clears the opposite bit" from "any write clears it" and from "no exclusion at all". The commit and lock are exercised with the right key, a wrong key, and a wide write to the commit register while closed and while open, which shows whether the lock gates commit writes and how many bits are kept. Sampling the pads one and two edges after a pull write tells the slow path from the fast one. Writes to unmapped offsets and to the reserved upper bits show that no stray decode takes place.

// File: rtl/gpio_padcfg_pkg.sv
package gpio_padcfg_pkg;

    localparam logic [31:0] OFS_AFSEL  = 32'h0000_0420;
    localparam logic [31:0] OFS_PULLUP = 32'h0000_0510;
    localparam logic [31:0] OFS_PULLDN = 32'h0000_0514;
    localparam logic [31:0] OFS_DIGEN  = 32'h0000_051C;
    localparam logic [31:0] OFS_LOCK   = 32'h0000_0520;
    localparam logic [31:0] OFS_COMMIT = 32'h0000_0524;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_AFSEL  = 3'd1,
        SEL_PULLUP = 3'd2,
        SEL_PULLDN = 3'd3,
        SEL_DIGEN  = 3'd4,
        SEL_LOCK   = 3'd5,
        SEL_COMMIT = 3'd6
    } padcfg_sel_e;

endpackage

// File: rtl/padcfg_decode.sv
module padcfg_decode
    import gpio_padcfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output padcfg_sel_e       sel_o
);
    localparam logic [ADDR_W-1:0] A_AFSEL  = OFS_AFSEL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_PULLUP = OFS_PULLUP[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_PULLDN = OFS_PULLDN[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_DIGEN  = OFS_DIGEN[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_LOCK   = OFS_LOCK[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_COMMIT = OFS_COMMIT[ADDR_W-1:0];

    always_comb begin
        unique case (addr_i)
            A_AFSEL:  sel_o = SEL_AFSEL;
            A_PULLUP: sel_o = SEL_PULLUP;
            A_PULLDN: sel_o = SEL_PULLDN;
            A_DIGEN:  sel_o = SEL_DIGEN;
            A_LOCK:   sel_o = SEL_LOCK;
            A_COMMIT: sel_o = SEL_COMMIT;
            default:  sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/padcfg_guard.sv
// Keyed lock and the per-pin commit mask it protects.
module padcfg_guard #(
    parameter int               NPINS      = 8,
    parameter int               DATA_W     = 32,
    parameter logic [DATA_W-1:0] KEY       = 32'h5AFE_C0DE,
    parameter logic [NPINS-1:0] RST_COMMIT = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_we_i,
    input  logic              commit_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              lock_open_o,
    output logic [NPINS-1:0]  commit_o
);
    typedef struct packed {
        logic             open;
        logic [NPINS-1:0] cmt;
    } guard_t;

    guard_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (lock_we_i) begin
            state_d.open = (wdata_i == KEY);
        end
        if (commit_we_i && state_q.open) begin
            state_d.cmt = wdata_i[NPINS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.open <= 1'b0;
            state_q.cmt  <= RST_COMMIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign lock_open_o = state_q.open;
    assign commit_o    = state_q.cmt;
endmodule

// File: rtl/padcfg_pads.sv
// Commit-masked pad configuration storage with pull exclusivity.
module padcfg_pads
    import gpio_padcfg_pkg::*;
#(
    parameter int               NPINS     = 8,
    parameter logic [NPINS-1:0] RST_AFSEL = '0,
    parameter logic [NPINS-1:0] RST_PU    = '0,
    parameter logic [NPINS-1:0] RST_PD    = '0,
    parameter logic [NPINS-1:0] RST_DEN   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  padcfg_sel_e      sel_i,
    input  logic [NPINS-1:0] wdata_i,
    input  logic [NPINS-1:0] commit_i,
    output logic [NPINS-1:0] afsel_o,
    output logic [NPINS-1:0] pu_o,
    output logic [NPINS-1:0] pd_o,
    output logic [NPINS-1:0] den_o
);
    typedef struct packed {
        logic [NPINS-1:0] af;
        logic [NPINS-1:0] pu;
        logic [NPINS-1:0] pd;
        logic [NPINS-1:0] den;
    } pads_t;

    pads_t            state_d, state_q;
    logic [NPINS-1:0] set_bits;

    always_comb begin
        state_d  = state_q;
        set_bits = wdata_i & commit_i;
        if (we_i) begin
            unique case (sel_i)
                SEL_AFSEL: state_d.af  = (state_q.af & ~commit_i) | set_bits;
                SEL_DIGEN: state_d.den = (state_q.den & ~commit_i) | set_bits;
                SEL_PULLUP: begin
                    state_d.pu = (state_q.pu & ~commit_i) | set_bits;
                    state_d.pd = state_q.pd & ~set_bits;
                end
                SEL_PULLDN: begin
                    state_d.pd = (state_q.pd & ~commit_i) | set_bits;
                    state_d.pu = state_q.pu & ~set_bits;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.af  <= RST_AFSEL;
            state_q.pu  <= RST_PU;
            state_q.pd  <= RST_PD;
            state_q.den <= RST_DEN;
        end else begin
            state_q <= state_d;
        end
    end

    assign afsel_o = state_q.af;
    assign pu_o    = state_q.pu;
    assign pd_o    = state_q.pd;
    assign den_o   = state_q.den;
endmodule

// File: rtl/padcfg_pull_stage.sv
// Pull path to the pads: direct (fast) or one extra register (slow).
module padcfg_pull_stage #(
    parameter int               NPINS     = 8,
    parameter bit               FAST_PULL = 1'b0,
    parameter logic [NPINS-1:0] RST_PU    = '0,
    parameter logic [NPINS-1:0] RST_PD    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pu_i,
    input  logic [NPINS-1:0] pd_i,
    output logic [NPINS-1:0] pu_o,
    output logic [NPINS-1:0] pd_o
);
    generate
        if (FAST_PULL) begin : g_fast
            assign pu_o = pu_i;
            assign pd_o = pd_i;
        end else begin : g_slow
            typedef struct packed {
                logic [NPINS-1:0] pu;
                logic [NPINS-1:0] pd;
            } pull_t;

            pull_t stage_d, stage_q;

            always_comb begin
                stage_d.pu = pu_i;
                stage_d.pd = pd_i;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q.pu <= RST_PU;
                    stage_q.pd <= RST_PD;
                end else begin
                    stage_q <= stage_d;
                end
            end

            assign pu_o = stage_q.pu;
            assign pd_o = stage_q.pd;
        end
    endgenerate
endmodule

// File: rtl/gpio_padcfg_bank.sv
module gpio_padcfg_bank
    import gpio_padcfg_pkg::*;
#(
    parameter int               NPINS      = 8,
    parameter int               ADDR_W     = 12,
    parameter int               DATA_W     = 32,
    parameter logic [31:0]      LOCK_KEY   = 32'h5AFE_C0DE,
    parameter bit               FAST_PULL  = 1'b0,
    parameter logic [NPINS-1:0] RST_AFSEL  = '0,
    parameter logic [NPINS-1:0] RST_PU     = '0,
    parameter logic [NPINS-1:0] RST_PD     = '0,
    parameter logic [NPINS-1:0] RST_DEN    = '0,
    parameter logic [NPINS-1:0] RST_COMMIT = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [NPINS-1:0]  pad_afsel_o,
    output logic [NPINS-1:0]  pad_pu_o,
    output logic [NPINS-1:0]  pad_pd_o,
    output logic [NPINS-1:0]  pad_den_o
);
    localparam int PAD_GAP = DATA_W - NPINS;

    padcfg_sel_e      sel;
    logic             lock_open;
    logic [NPINS-1:0] cmt_q;
    logic [NPINS-1:0] af_q, pu_q, pd_q, den_q;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    padcfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    padcfg_guard #(
        .NPINS      (NPINS),
        .DATA_W     (DATA_W),
        .KEY        (LOCK_KEY[DATA_W-1:0]),
        .RST_COMMIT (RST_COMMIT)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_we_i   (wr_en_i && (sel == SEL_LOCK)),
        .commit_we_i (wr_en_i && (sel == SEL_COMMIT)),
        .wdata_i     (wr_data_i),
        .lock_open_o (lock_open),
        .commit_o    (cmt_q)
    );

    padcfg_pads #(
        .NPINS     (NPINS),
        .RST_AFSEL (RST_AFSEL),
        .RST_PU    (RST_PU),
        .RST_PD    (RST_PD),
        .RST_DEN   (RST_DEN)
    ) u_pads (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wr_en_i),
        .sel_i    (sel),
        .wdata_i  (wr_data_i[NPINS-1:0]),
        .commit_i (cmt_q),
        .afsel_o  (af_q),
        .pu_o     (pu_q),
        .pd_o     (pd_q),
        .den_o    (den_q)
    );

    padcfg_pull_stage #(
        .NPINS     (NPINS),
        .FAST_PULL (FAST_PULL),
        .RST_PU    (RST_PU),
        .RST_PD    (RST_PD)
    ) u_pull (
        .clk   (clk),
        .rst_n (rst_n),
        .pu_i  (pu_q),
        .pd_i  (pd_q),
        .pu_o  (pad_pu_o),
        .pd_o  (pad_pd_o)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) begin
            unique case (sel)
                SEL_AFSEL:  rd_d.rdata = {{PAD_GAP{1'b0}}, af_q};
                SEL_PULLUP: rd_d.rdata = {{PAD_GAP{1'b0}}, pu_q};
                SEL_PULLDN: rd_d.rdata = {{PAD_GAP{1'b0}}, pd_q};
                SEL_DIGEN:  rd_d.rdata = {{PAD_GAP{1'b0}}, den_q};
                SEL_COMMIT: rd_d.rdata = {{PAD_GAP{1'b0}}, cmt_q};
                SEL_LOCK:   rd_d.rdata = {{(DATA_W-1){1'b0}}, ~lock_open};
                default:    rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q.rdata <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o   = rd_q.rdata;
    assign pad_afsel_o = af_q;
    assign pad_den_o   = den_q;
endmodule

// File: rtl/gpio_padcfg_bank_chk.sv
module gpio_padcfg_bank_chk #(
    parameter int NPINS     = 8,
    parameter int DATA_W    = 32,
    parameter bit FAST_PULL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock_open,
    input logic [NPINS-1:0]  cmt_q,
    input logic [NPINS-1:0]  af_q,
    input logic [NPINS-1:0]  pu_q,
    input logic [NPINS-1:0]  pd_q,
    input logic [NPINS-1:0]  den_q,
    input logic [NPINS-1:0]  pad_pu_o,
    input logic [NPINS-1:0]  pad_pd_o,
    input logic [DATA_W-1:0] rd_data_o
);
    assert_pull_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_q & pd_q) == '0);

    assert_pad_pull_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_o & pad_pd_o) == '0);

    assert_af_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((af_q ^ $past(af_q)) & ~$past(cmt_q)) == '0);

    assert_den_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((den_q ^ $past(den_q)) & ~$past(cmt_q)) == '0);

    assert_pull_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (((pu_q ^ $past(pu_q)) | (pd_q ^ $past(pd_q))) & ~$past(cmt_q)) == '0);

    assert_commit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lock_open) |-> $stable(cmt_q));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:NPINS] == '0);

    generate
        if (!FAST_PULL) begin : g_slow_chk
            assert_slow_pu_R8: assert property (@(posedge clk) disable iff (!rst_n)
                pad_pu_o == $past(pu_q));
            assert_slow_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
                pad_pd_o == $past(pd_q));
        end else begin : g_fast_chk
            assert_fast_pu_R8: assert property (@(posedge clk) disable iff (!rst_n)
                pad_pu_o == pu_q);
        end
    endgenerate
endmodule

bind gpio_padcfg_bank gpio_padcfg_bank_chk #(
    .NPINS     (NPINS),
    .DATA_W    (DATA_W),
    .FAST_PULL (FAST_PULL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_open (lock_open),
    .cmt_q     (cmt_q),
    .af_q      (af_q),
    .pu_q      (pu_q),
    .pd_q      (pd_q),
    .den_q     (den_q),
    .pad_pu_o  (pad_pu_o),
    .pad_pd_o  (pad_pd_o),
    .rd_data_o (rd_data_o)
);

// File: tb/gpio_padcfg_bank_tb.sv
module gpio_padcfg_bank_tb;
    localparam logic [11:0] A_AF   = 12'h420;
    localparam logic [11:0] A_PU   = 12'h510;
    localparam logic [11:0] A_PD   = 12'h514;
    localparam logic [11:0] A_DEN  = 12'h51C;
    localparam logic [11:0] A_LOCK = 12'h520;
    localparam logic [11:0] A_CMT  = 12'h524;
    localparam logic [31:0] KEY    = 32'h5AFE_C0DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  p_af, p_pu, p_pd, p_den;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    gpio_padcfg_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr),
        .wr_data_i   (wdata),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .rd_data_o   (rdata),
        .pad_afsel_o (p_af),
        .pad_pu_o    (p_pu),
        .pad_pd_o    (p_pd),
        .pad_den_o   (p_den)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        check("R7 pad_afsel reset", {24'd0, p_af}, 32'h0);
        check("R7 pad_pu reset", {24'd0, p_pu}, 32'h0);
        check("R7 pad_pd reset", {24'd0, p_pd}, 32'h0);
        check("R7 pad_den reset", {24'd0, p_den}, 32'h0);
        expect_reg("R7 commit reset", A_CMT, 32'hFE);
        expect_reg("R5 lock closed after reset", A_LOCK, 32'h1);
        expect_reg("R1 afsel reset read", A_AF, 32'h0);
    endtask

    task automatic t_masked_write();
        bus_write(A_AF, 32'hFFFF_FFFF);
        expect_reg("R4 R2 afsel pin0 locked, upper zero", A_AF, 32'hFE);
        bus_write(A_DEN, 32'h0000_0081);
        expect_reg("R4 den masked", A_DEN, 32'h80);
        check("R4 pad_den output", {24'd0, p_den}, 32'h80);
        check("R1 pad_afsel output", {24'd0, p_af}, 32'hFE);
    endtask

    task automatic t_pull_exclusive();
        bus_write(A_PU, 32'h0F);
        expect_reg("R3 pullup set", A_PU, 32'h0E);
        bus_write(A_PD, 32'h3C);
        expect_reg("R3 pulldown set", A_PD, 32'h3C);
        expect_reg("R3 pulldown cleared pullup", A_PU, 32'h02);
        bus_write(A_PU, 32'h00);
        expect_reg("R3 pullup zero", A_PU, 32'h00);
        expect_reg("R3 zero write keeps pulldown", A_PD, 32'h3C);
        check("R3 pad_pd after settle", {24'd0, p_pd}, 32'h3C);
    endtask

    task automatic t_latency();
        @(negedge clk);
        addr = A_PU; wdata = 32'h20; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 pad_pu one edge after", {24'd0, p_pu}, 32'h00);
        check("R8 pad_pd one edge after", {24'd0, p_pd}, 32'h3C);
        @(posedge clk);
        @(negedge clk);
        check("R8 pad_pu two edges after", {24'd0, p_pu}, 32'h20);
        check("R8 pad_pd two edges after", {24'd0, p_pd}, 32'h1C);
        @(negedge clk);
        addr = A_DEN; wdata = 32'h90; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 pad_den one edge after", {24'd0, p_den}, 32'h90);
    endtask

    task automatic t_commit_closed();
        bus_write(A_CMT, 32'hFF);
        expect_reg("R6 commit ignored while closed", A_CMT, 32'hFE);
        bus_write(A_PU, 32'h01);
        expect_reg("R4 locked pin pullup held", A_PU, 32'h00);
    endtask

    task automatic t_unlock();
        bus_write(A_LOCK, KEY);
        expect_reg("R5 lock open", A_LOCK, 32'h0);
        bus_write(A_CMT, 32'hFFFF_FF01);
        expect_reg("R6 R2 commit low bits written", A_CMT, 32'h01);
        bus_write(A_LOCK, KEY ^ 32'h1);
        expect_reg("R5 wrong key closes", A_LOCK, 32'h1);
        bus_write(A_CMT, 32'hFF);
        expect_reg("R6 commit held after close", A_CMT, 32'h01);
        bus_write(A_AF, 32'h01);
        expect_reg("R4 only pin0 writable", A_AF, 32'hFF);
        bus_write(A_PD, 32'hFF);
        expect_reg("R4 pulldown pin0 only", A_PD, 32'h1D);
        bus_write(A_LOCK, KEY);
        bus_write(A_CMT, 32'hFF);
        bus_write(A_LOCK, 32'h0);
        expect_reg("R6 commit reopened all", A_CMT, 32'hFF);
        bus_write(A_DEN, 32'h01);
        expect_reg("R4 den all committed", A_DEN, 32'h01);
    endtask

    task automatic t_unmapped();
        bus_write(12'h000, 32'hFF);
        bus_write(12'h518, 32'hFF);
        expect_reg("R9 unmapped read 0x518", 12'h518, 32'h0);
        expect_reg("R9 unmapped read 0x000", 12'h000, 32'h0);
        expect_reg("R9 afsel unchanged", A_AF, 32'hFF);
        expect_reg("R9 pulldown unchanged", A_PD, 32'h1D);
        expect_reg("R9 den unchanged", A_DEN, 32'h01);
        expect_reg("R9 commit unchanged", A_CMT, 32'hFF);
    endtask

    task automatic t_reserved();
        bus_write(A_PU, 32'hFFFF_FF00);
        expect_reg("R2 upper bits discarded", A_PU, 32'h00);
        expect_reg("R2 pulldown untouched", A_PD, 32'h1D);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_write();
        t_pull_exclusive();
        t_latency();
        t_commit_closed();
        t_unlock();
        t_unmapped();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule